// File: doc/BRIEF.md
# Cascadable Dual-Half Timer/Counter Unit

This block holds a number of timer pairs behind a simple register bus. Each pair has an A half and a B half, and each half is a 16-bit up/down counter. A half counts either every module clock (timer mode) or on events of its external input (counter mode). An event is a rising edge, a falling edge, either edge, or a clock cycle in which the input is high. The input can be inverted and can pass through a two-flop synchroniser first.

Setting the cascade bit of an A half joins it with its B partner into one 32-bit counter, which is then controlled only through the A half. A write-only run register per half starts, stops and optionally reloads the counter. A stopped half therefore resumes from its held count unless a reload is requested. When a half reaches its terminal value it raises a pending interrupt bit. It then either reloads (cyclic) or stops (one-shot). Pending bits are gated by an enable word, drive registered interrupt outputs, and are cleared by writing ones.

Top module: `gp_timer_unit`

## Requirements
- R1: After reset every count, control word, pending bit, enable bit and `irq_o` is 0. The ID word at 0x08 reads MODULE_ID in bits 15:8 and NUM_PAIRS in bits 7:5, with all other bits 0.
- R2: In timer mode (control bit 2 = 0, bit 9 = 0) an enabled half steps by one on every clock: up when control bit 1 is 1, down when it is 0.
- R3: The run word has three bits: bit 0 starts, bit 1 stops, and bit 2 loads the reload value into the count at a start. Stop wins over start. A start without bit 2 resumes from the held count. The count does not step on the cycle of a run write. Control bit 0 reads the enable state.
- R4: With control bit 3 = 0 (cyclic), a step taken at the terminal value (0xFFFF going up, 0 going down) sets the half's pending bit and loads the reload value.
- R5: With control bit 3 = 1 (one-shot), the terminal step sets the pending bit, clears the enable and holds the count.
- R6: A half that is not cascaded uses only bits 15:0 of its reload word, and its count reads zero-extended.
- R7: Control bit 4 of an A half (the B half has no such bit) cascades the pair into a 32-bit counter. It counts under the A half's control, with a 32-bit reload and a 0xFFFFFFFF terminal value going up. The A count reads all 32 bits, the B count reads the upper 16 bits, and run writes to the B half are ignored.
- R8: In counter mode (control bit 2 = 1) or with external clock (bit 9 = 1), bits 7:6 select the event: 0 = each cycle the input is high, 1 = rising edge, 2 = falling edge, 3 = both edges. Bit 10 = 1 forces level counting.
- R9: Control bit 5 inverts the input before detection. Bit 8 routes it through a two-flop synchroniser; with bit 8 clear the raw input is used.
- R10: Half h of pair p owns pending bit 2p+h (A = 0, B = 1). The pending word reads at 0xFC, and writing ones there clears those bits. The enable word is at 0xF4. `irq_o` is the AND of pending and enable, registered one clock.
- R11: For half h of pair p, the register addresses are: control at 0x10, run at 0x18, reload at 0x20 and count at 0x28, each plus 0x20·p + 4·h. `bus_rdata` returns the word addressed on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_in | input | 2·NUM_PAIRS | External input per half |
| irq_o | output | 2·NUM_PAIRS | Interrupt per half |

## Verification
A corrupted count or enable flop shows at the count register on the next read, and as a missing or extra pending bit once the terminal value is crossed. The stop, resume and reload checks therefore read counts after an exactly known number of stepping cycles. A broken input path shows as a wrong event tally in counter mode, which the bench reads after the synchroniser delay has passed. Interrupt faults show on `irq_o` one clock after the pending or enable word changes.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int OFF_ID   = 'h08;
  localparam int OFF_CTRL = 'h10;
  localparam int OFF_RUN  = 'h18;
  localparam int OFF_RLD  = 'h20;
  localparam int OFF_CNT  = 'h28;
  localparam int OFF_IE   = 'hF4;
  localparam int OFF_STAT = 'hFC;
  localparam int PAIR_STRIDE = 'h20;
  localparam int HALF_STRIDE = 4;

  localparam int RUN_START = 0;
  localparam int RUN_STOP  = 1;
  localparam int RUN_LOAD  = 2;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_FALL  = 2'd2,
    EV_BOTH  = 2'd3
  } ev_sel_t;

  // control bits 10:1 in positional order
  typedef struct packed {
    logic    lvl_force;
    logic    ext_clk;
    logic    sync_on;
    ev_sel_t ev_sel;
    logic    invert;
    logic    cascade;
    logic    oneshot;
    logic    cnt_mode;
    logic    up;
  } half_cfg_t;

  typedef struct packed {
    logic [31:0] nxt;
    logic        hit;
  } step_t;

  function automatic int half_addr(input int h, input int off);
    return off + PAIR_STRIDE * (h / 2) + HALF_STRIDE * (h % 2);
  endfunction

  function automatic step_t step_count(input logic [31:0] cur,
                                       input logic [31:0] rld,
                                       input logic up,
                                       input logic wide,
                                       input logic oneshot);
    step_t r;
    logic [31:0] lim;
    lim   = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    r.hit = up ? (cur == lim) : (cur == 32'h0);
    if (r.hit) r.nxt = oneshot ? cur : (rld & lim);
    else       r.nxt = (up ? cur + 32'd1 : cur - 32'd1) & lim;
    return r;
  endfunction

endpackage

// File: rtl/gpt_input_cond.sv
module gpt_input_cond
  import gpt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ext_i,
  input  logic    sync_on,
  input  logic    invert,
  input  logic    lvl_force,
  input  ev_sel_t ev_sel,
  input  logic    ext_clk,
  input  logic    cnt_mode,
  output logic    tick_o
);
  logic s1, s2, prev, smp, rise, fall, evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= ext_i;
      s2   <= s1;
      prev <= smp;
    end
  end

  always_comb begin
    smp  = (sync_on ? s2 : ext_i) ^ invert;
    rise = smp & ~prev;
    fall = ~smp & prev;
    if (lvl_force || ev_sel == EV_LEVEL) evt = smp;
    else begin
      case (ev_sel)
        EV_RISE: evt = rise;
        EV_FALL: evt = fall;
        default: evt = rise | fall;
      endcase
    end
    tick_o = (!cnt_mode && !ext_clk) ? 1'b1 : evt;
  end
endmodule

// File: rtl/gpt_pair.sv
module gpt_pair
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctrl_we,
  input  logic [1:0]       run_we,
  input  logic [1:0]       rld_we,
  input  logic [31:0]      wdata,
  input  logic [1:0]       ext_i,
  output logic [1:0][10:0] ctrl_q,
  output logic [31:0]      cnt_a_q,
  output logic [15:0]      cnt_b_q,
  output logic [1:0]       en_q,
  output logic [1:0]       term_o
);
  half_cfg_t   cfg_a, cfg_b;
  logic [31:0] rld_a;
  logic [15:0] rld_b;
  logic [31:0] cnt;
  logic [1:0]  en, tick, cmd, fire;
  logic        casc;
  step_t       sa, sb;

  gpt_input_cond u_in_a (
    .clk(clk), .rst(rst), .ext_i(ext_i[0]), .sync_on(cfg_a.sync_on),
    .invert(cfg_a.invert), .lvl_force(cfg_a.lvl_force), .ev_sel(cfg_a.ev_sel),
    .ext_clk(cfg_a.ext_clk), .cnt_mode(cfg_a.cnt_mode), .tick_o(tick[0]));

  gpt_input_cond u_in_b (
    .clk(clk), .rst(rst), .ext_i(ext_i[1]), .sync_on(cfg_b.sync_on),
    .invert(cfg_b.invert), .lvl_force(cfg_b.lvl_force), .ev_sel(cfg_b.ev_sel),
    .ext_clk(cfg_b.ext_clk), .cnt_mode(cfg_b.cnt_mode), .tick_o(tick[1]));

  assign casc = cfg_a.cascade;

  always_comb begin
    sa = step_count(casc ? cnt : {16'h0, cnt[15:0]},
                    rld_a, cfg_a.up, casc, cfg_a.oneshot);
    sb = step_count({16'h0, cnt[31:16]}, {16'h0, rld_b},
                    cfg_b.up, 1'b0, cfg_b.oneshot);
    cmd[0]  = run_we[0] & (wdata[RUN_START] | wdata[RUN_STOP]);
    cmd[1]  = run_we[1] & (wdata[RUN_START] | wdata[RUN_STOP]);
    fire[0] = en[0] & tick[0] & ~cmd[0];
    fire[1] = ~casc & en[1] & tick[1] & ~cmd[1];
    term_o  = {fire[1] & sb.hit, fire[0] & sa.hit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a <= '0;
      cfg_b <= '0;
      rld_a <= '0;
      rld_b <= '0;
      cnt   <= '0;
      en    <= '0;
    end else begin
      if (ctrl_we[0]) cfg_a <= half_cfg_t'(wdata[10:1]);
      if (ctrl_we[1]) cfg_b <= half_cfg_t'(wdata[10:1] & ~10'h008);
      if (rld_we[0])  rld_a <= wdata;
      if (rld_we[1])  rld_b <= wdata[15:0];

      // A half, drives the whole pair when cascaded
      if (run_we[0] && wdata[RUN_STOP]) en[0] <= 1'b0;
      else if (run_we[0] && wdata[RUN_START]) begin
        en[0] <= 1'b1;
        if (wdata[RUN_LOAD]) begin
          cnt[15:0] <= rld_a[15:0];
          if (casc) cnt[31:16] <= rld_a[31:16];
        end
      end else if (fire[0]) begin
        if (casc) cnt <= sa.nxt;
        else      cnt[15:0] <= sa.nxt[15:0];
        if (sa.hit && cfg_a.oneshot) en[0] <= 1'b0;
      end

      // B half, idle while cascaded
      if (!casc) begin
        if (run_we[1] && wdata[RUN_STOP]) en[1] <= 1'b0;
        else if (run_we[1] && wdata[RUN_START]) begin
          en[1] <= 1'b1;
          if (wdata[RUN_LOAD]) cnt[31:16] <= rld_b;
        end else if (fire[1]) begin
          cnt[31:16] <= sb.nxt[15:0];
          if (sb.hit && cfg_b.oneshot) en[1] <= 1'b0;
        end
      end
    end
  end

  assign ctrl_q[0] = {cfg_a, en[0]};
  assign ctrl_q[1] = {cfg_b, en[1]};
  assign cnt_a_q   = casc ? cnt : {16'h0, cnt[15:0]};
  assign cnt_b_q   = cnt[31:16];
  assign en_q      = en;
endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
  import gpt_pkg::*;
#(
  parameter int       NUM_PAIRS = 2,
  parameter int       ADDR_W    = 8,
  parameter bit [7:0] MODULE_ID = 8'h5A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [2*NUM_PAIRS-1:0] ext_in,
  output logic [2*NUM_PAIRS-1:0] irq_o
);
  localparam int NH = 2 * NUM_PAIRS;

  logic [NH-1:0] ctrl_we, run_we, rld_we, en_vec, term_vec, pending, irq_en;
  logic [10:0]   ctrl_r [NH];
  logic [31:0]   cnt_r  [NH];
  logic          ie_we, stat_we;
  logic [31:0]   rmux;

  always_comb begin
    ie_we   = bus_we && bus_addr == ADDR_W'(OFF_IE);
    stat_we = bus_we && bus_addr == ADDR_W'(OFF_STAT);
    for (int i = 0; i < NH; i++) begin
      ctrl_we[i] = bus_we && bus_addr == ADDR_W'(half_addr(i, OFF_CTRL));
      run_we[i]  = bus_we && bus_addr == ADDR_W'(half_addr(i, OFF_RUN));
      rld_we[i]  = bus_we && bus_addr == ADDR_W'(half_addr(i, OFF_RLD));
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [1:0][10:0] cq;
    logic [31:0]      ca;
    logic [15:0]      cb;
    gpt_pair u_pair (
      .clk(clk), .rst(rst),
      .ctrl_we(ctrl_we[2*p+1:2*p]), .run_we(run_we[2*p+1:2*p]),
      .rld_we(rld_we[2*p+1:2*p]), .wdata(bus_wdata),
      .ext_i(ext_in[2*p+1:2*p]), .ctrl_q(cq), .cnt_a_q(ca), .cnt_b_q(cb),
      .en_q(en_vec[2*p+1:2*p]), .term_o(term_vec[2*p+1:2*p]));
    assign ctrl_r[2*p]   = cq[0];
    assign ctrl_r[2*p+1] = cq[1];
    assign cnt_r[2*p]    = ca;
    assign cnt_r[2*p+1]  = {16'h0, cb};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      irq_en  <= '0;
      irq_o   <= '0;
    end else begin
      pending <= (pending & ~(stat_we ? bus_wdata[NH-1:0] : '0)) | term_vec;
      if (ie_we) irq_en <= bus_wdata[NH-1:0];
      irq_o <= pending & irq_en;
    end
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == ADDR_W'(OFF_ID))
      rmux = {16'h0, MODULE_ID, 3'(NUM_PAIRS), 5'h0};
    if (bus_addr == ADDR_W'(OFF_IE))   rmux = 32'(irq_en);
    if (bus_addr == ADDR_W'(OFF_STAT)) rmux = 32'(pending);
    for (int i = 0; i < NH; i++) begin
      if (bus_addr == ADDR_W'(half_addr(i, OFF_CTRL))) rmux = {21'h0, ctrl_r[i]};
      if (bus_addr == ADDR_W'(half_addr(i, OFF_CNT)))  rmux = cnt_r[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rmux;
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
  import gpt_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [2*NUM_PAIRS-1:0] irq_o,
  input logic [2*NUM_PAIRS-1:0] pending,
  input logic [2*NUM_PAIRS-1:0] irq_en,
  input logic [2*NUM_PAIRS-1:0] en_vec,
  input logic [2*NUM_PAIRS-1:0] term_vec
);
  localparam int NH = 2 * NUM_PAIRS;

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (irq_o == '0))
    else $error("irq_o not cleared by reset");

  for (genvar i = 0; i < NH; i++) begin : g_chk
    logic stop_wr, clr_wr;
    assign stop_wr = bus_we && bus_addr == ADDR_W'(half_addr(i, OFF_RUN)) && bus_wdata[RUN_STOP];
    assign clr_wr  = bus_we && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[i];

    if ((i % 2) == 0) begin : g_a
      assert_stop_clears_R3: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !en_vec[i])
        else $error("stop did not clear enable of half %0d", i);

      assert_enable_fall_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(en_vec[i]) |-> $past(stop_wr || term_vec[i]))
        else $error("enable of half %0d fell without stop or terminal", i);
    end

    assert_pending_source_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(pending[i]) |-> $past(term_vec[i]))
      else $error("pending %0d rose without terminal step", i);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !term_vec[i]) |=> !pending[i])
      else $error("pending %0d not cleared", i);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
      irq_o[i] |-> $past(irq_en[i]))
      else $error("irq %0d raised while disabled", i);
  end
endmodule

bind gp_timer_unit gpt_checker #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gp_timer_unit.sv
module tb_gp_timer_unit;
  localparam int NP = 2;
  localparam int NH = 2 * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] ext_in = '0;
  logic [NH-1:0] irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  gp_timer_unit #(.NUM_PAIRS(NP), .ADDR_W(8), .MODULE_ID(8'h5A)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq_o(irq_o));

  always #10 clk = ~clk;

  function automatic logic [7:0] ha(input int h, input int off);
    return 8'(off + 32 * (h / 2) + 4 * (h % 2));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 32'h0);
    rd(ha(0, 'h28), d); check("R1 count", d, 32'h0);
    rd(ha(2, 'h10), d); check("R1 ctrl", d, 32'h0);
    rd(8'h08, d);       check("R1 id", d, 32'h5A40);
  endtask

  task automatic t_timer_down();
    logic [31:0] d;
    wr(ha(0, 'h20), 32'd100);
    wr(ha(0, 'h10), 32'h000);
    wr(ha(0, 'h18), 32'h5);
    idle(3);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R2 down steps", d, 32'd97);
  endtask

  task automatic t_run_cmds();
    logic [31:0] d;
    wr(ha(0, 'h20), 32'd10);
    wr(ha(0, 'h10), 32'h002);
    wr(ha(0, 'h18), 32'h5);
    rd(ha(0, 'h10), d); check("R3 enable reads 1", d, 32'h003);
    idle(1);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R2 up steps", d, 32'd12);
    wr(ha(0, 'h18), 32'h1);
    idle(1);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R3 resume", d, 32'd13);
    wr(ha(0, 'h18), 32'h5);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R3 restart reload", d, 32'd10);
    wr(ha(0, 'h18), 32'h3);
    rd(ha(0, 'h10), d); check("R3 stop wins", d, 32'h002);
  endtask

  task automatic t_cyclic();
    logic [31:0] d;
    wr(8'hFC, 32'hF);
    wr(ha(0, 'h20), 32'h0000FFFD);
    wr(ha(0, 'h10), 32'h002);
    wr(ha(0, 'h18), 32'h5);
    idle(4);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R4 cyclic reload", d, 32'h0000FFFE);
    rd(8'hFC, d);       check("R4 pending set", d & 32'h1, 32'h1);
  endtask

  task automatic t_oneshot_irq();
    logic [31:0] d;
    wr(8'hFC, 32'hF);
    wr(8'hF4, 32'h0);
    wr(ha(2, 'h20), 32'd3);
    wr(ha(2, 'h10), 32'h008);
    wr(ha(2, 'h18), 32'h5);
    idle(10);
    rd(ha(2, 'h28), d); check("R5 count held", d, 32'h0);
    rd(ha(2, 'h10), d); check("R5 enable cleared", d, 32'h008);
    rd(8'hFC, d);       check("R10 pending index", d, 32'h4);
    check("R10 irq masked", 32'(irq_o), 32'h0);
    wr(8'hF4, 32'h4);
    idle(1);
    check("R10 irq raised", 32'(irq_o), 32'h4);
    wr(8'hFC, 32'h4);
    idle(1);
    check("R10 irq after clear", 32'(irq_o), 32'h0);
    rd(8'hFC, d); check("R10 pending cleared", d, 32'h0);
    wr(8'hF4, 32'h0);
  endtask

  task automatic t_width16();
    logic [31:0] d;
    wr(ha(3, 'h20), 32'h0001FFFE);
    wr(ha(3, 'h10), 32'h002);
    wr(ha(3, 'h18), 32'h5);
    idle(1);
    wr(ha(3, 'h18), 32'h2);
    rd(ha(3, 'h28), d); check("R6 low half reload", d, 32'h0000FFFF);
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    wr(ha(0, 'h20), 32'h0000FFFE);
    wr(ha(0, 'h10), 32'h012);
    wr(ha(0, 'h18), 32'h5);
    idle(2);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R7 carry into B", d, 32'h00010000);
    rd(ha(1, 'h28), d); check("R7 B reads upper", d, 32'h0001);
    wr(ha(1, 'h18), 32'h5);
    idle(2);
    rd(ha(0, 'h28), d); check("R7 B run ignored", d, 32'h00010000);
    wr(ha(0, 'h20), 32'h00010000);
    wr(ha(0, 'h10), 32'h010);
    wr(ha(0, 'h18), 32'h5);
    idle(1);
    wr(ha(0, 'h18), 32'h2);
    rd(ha(0, 'h28), d); check("R7 borrow from B", d, 32'h0000FFFF);
    wr(ha(0, 'h10), 32'h000);
  endtask

  task automatic run_counter(input logic [31:0] cfg, input int np, input bit fin_high,
                             output logic [31:0] res);
    wr(ha(3, 'h20), 32'h0);
    wr(ha(3, 'h10), cfg);
    wr(ha(3, 'h18), 32'h5);
    for (int k = 0; k < np; k++) begin
      ext_in[3] = 1'b1; idle(4);
      ext_in[3] = 1'b0; idle(4);
    end
    if (fin_high) begin ext_in[3] = 1'b1; idle(4); end
    idle(6);
    wr(ha(3, 'h18), 32'h2);
    rd(ha(3, 'h28), res);
    ext_in[3] = 1'b0;
    idle(6);
  endtask

  task automatic t_counter_events();
    logic [31:0] d;
    run_counter(32'h146, 3, 1, d); check("R8 rising", d, 32'd4);
    run_counter(32'h186, 3, 1, d); check("R8 falling", d, 32'd3);
    run_counter(32'h1C6, 3, 1, d); check("R8 both", d, 32'd7);
    run_counter(32'h106, 2, 0, d); check("R8 level", d, 32'd8);
    run_counter(32'h546, 2, 0, d); check("R8 level forced", d, 32'd8);
  endtask

  task automatic t_invert_sync();
    logic [31:0] d;
    run_counter(32'h166, 3, 1, d); check("R9 inverted rising", d, 32'd3);
    run_counter(32'h046, 3, 1, d); check("R9 unsynced rising", d, 32'd4);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(ha(1, 'h10), 32'h7FF);
    rd(ha(1, 'h10), d); check("R11 B ctrl, no cascade bit", d, 32'h7EE);
    rd(ha(0, 'h10), d); check("R11 A ctrl untouched", d, 32'h000);
    wr(ha(1, 'h10), 32'h000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_timer_down();
    t_run_cmds();
    t_cyclic();
    t_oneshot_irq();
    t_width16();
    t_cascade();
    t_counter_events();
    t_invert_sync();
    t_map();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule